// File: doc/BRIEF.md
# Configuration Security Gate

This block sits between a programming port and the configuration store of a programmable logic device. It holds a bank of configuration words that can be written and read back for verify, a preload register that forces the device's register state for test, a 64-bit user signature, and a one-time security lock. All of these are reached through a single command port. Commands use a valid/ready handshake, and every accepted command produces a one-cycle response carrying read data and an error flag.

Setting the lock takes effect on the next cycle. From then on, verify reads of the configuration return zeros with an error, and preload commands are refused. The user signature stays readable and writable in every state. The only way to clear the lock is a full erase. A full erase sweeps every configuration word back to zero, and the port stays busy for one cycle per word while it does so.

The controller is a three-state machine. ST_OPEN is the unlocked state and accepts commands. ST_LOCKED is the secured state and accepts commands. ST_WIPE is the erase sweep, during which `cmd_ready` is low. The named transitions are:
- T_LOCK: ST_OPEN to ST_LOCKED, on an accepted lock command.
- T_ERASE_O: ST_OPEN to ST_WIPE, on an accepted erase.
- T_ERASE_L: ST_LOCKED to ST_WIPE, on an accepted erase.
- T_SWEPT: ST_WIPE to ST_OPEN, after the last word is cleared.

Top module: `sec_access_ctrl`

## Requirements
- R1: After reset the controller is in ST_OPEN with `cmd_ready`=1, `rsp_valid`=0, `locked`=0, `preload_q`=0, and all configuration and signature words equal to zero.
- R2: Opcodes are 0 write config, 1 verify, 2 preload, 3 signature read, 4 signature write, 5 lock, 6 erase and 7 illegal. A config write stores `cmd_wdata` at `cmd_addr`. A verify accepted while unlocked returns that word on `rsp_data`, with `rsp_err`=0, one cycle after acceptance.
- R3: A lock command raises `locked` on the cycle after acceptance, and `locked` stays high until an erase is accepted. A verify accepted on the very next cycle is already refused.
- R4: A refused verify returns `rsp_data`=0 with `rsp_err`=1 for exactly the one response cycle.
- R5: A preload accepted while unlocked loads `cmd_wdata` into `preload_q` on the next cycle. While locked, a preload leaves `preload_q` unchanged and responds with `rsp_err`=1.
- R6: Signature word k (k = `cmd_addr[2:0]`, eight 8-bit words) is written by opcode 4 and returned by opcode 3 with `rsp_err`=0, whether or not the lock is set.
- R7: An accepted erase clears `locked` on the next cycle and holds `cmd_ready` low for exactly 2^ADDR_W cycles. After that, every verify returns zero.
- R8: Opcode 7 responds with `rsp_err`=1 and `rsp_data`=0 and changes no state.
- R9: `rsp_valid` is high for exactly the cycle after each accepted command (`cmd_valid` and `cmd_ready` both high) and at no other time. A command presented while `cmd_ready` is low is not accepted.
- R10: A config write is accepted while locked and responds with `rsp_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| cmd_op | input | 3 | Command opcode |
| cmd_addr | input | ADDR_W | Config word index, or signature index in the low bits |
| cmd_wdata | input | DATA_W | Write or preload data |
| rsp_valid | output | 1 | Response strobe, one cycle after acceptance |
| rsp_data | output | DATA_W | Read data, zero for non-reads and refusals |
| rsp_err | output | 1 | Command refused or illegal |
| locked | output | 1 | Security lock state |
| preload_q | output | DATA_W | Preloaded register contents |

## Verification
A wrong state in the controller shows up at the ports within one response. A lost or stuck lock appears as a verify or preload that responds without the error flag when it should carry it, or with it when it should not, on the cycle after the command. A wrong sweep length appears as `cmd_ready` returning one or more cycles early or late. Skipped words in the sweep appear as nonzero data on the first verify after the erase.

// File: rtl/sec_pkg.sv
package sec_pkg;

    typedef enum logic [2:0] {
        OP_CFG_WR  = 3'd0,
        OP_VERIFY  = 3'd1,
        OP_PRELOAD = 3'd2,
        OP_SIG_RD  = 3'd3,
        OP_SIG_WR  = 3'd4,
        OP_LOCK    = 3'd5,
        OP_ERASE   = 3'd6,
        OP_BAD     = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_OPEN   = 2'd0,
        ST_LOCKED = 2'd1,
        ST_WIPE   = 2'd2
    } gate_state_e;

endpackage

// File: rtl/sec_word_bank.sv
module sec_word_bank #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] word_q [WORDS];

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q[i] <= '0;
            end else if (we && (waddr == ADDR_W'(i))) begin
                word_q[i] <= wdata;
            end
        end
    end

    assign rdata = word_q[raddr];

endmodule

// File: rtl/sec_ctrl_fsm.sv
module sec_ctrl_fsm
    import sec_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_fire,
    input  op_e               op,
    output logic              ready,
    output logic              is_locked,
    output logic              wipe_we,
    output logic [ADDR_W-1:0] wipe_addr,
    output logic              cfg_we,
    output logic              sig_we,
    output logic              pre_we
);
    localparam logic [ADDR_W-1:0] LAST_WORD = '1;

    gate_state_e       state_q, state_d;
    logic [ADDR_W-1:0] sweep_q;

    // state register and sweep counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OPEN;
            sweep_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_WIPE) begin
                sweep_q <= sweep_q + 1'b1;
            end else begin
                sweep_q <= '0;
            end
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN: begin
                if (cmd_fire && op == OP_LOCK) begin
                    state_d = ST_LOCKED;          // T_LOCK
                end else if (cmd_fire && op == OP_ERASE) begin
                    state_d = ST_WIPE;            // T_ERASE_O
                end
            end
            ST_LOCKED: begin
                if (cmd_fire && op == OP_ERASE) begin
                    state_d = ST_WIPE;            // T_ERASE_L
                end
            end
            ST_WIPE: begin
                if (sweep_q == LAST_WORD) begin
                    state_d = ST_OPEN;            // T_SWEPT
                end
            end
            default: state_d = ST_OPEN;
        endcase
    end

    // outputs
    always_comb begin
        ready     = (state_q != ST_WIPE);
        is_locked = (state_q == ST_LOCKED);
        wipe_we   = (state_q == ST_WIPE);
        wipe_addr = sweep_q;
        cfg_we    = cmd_fire && (op == OP_CFG_WR);
        sig_we    = cmd_fire && (op == OP_SIG_WR);
        pre_we    = cmd_fire && (op == OP_PRELOAD) && (state_q == ST_OPEN);
    end

endmodule

// File: rtl/sec_access_ctrl.sv
module sec_access_ctrl
    import sec_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 4,
    parameter int SIG_BITS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_err,
    output logic              locked,
    output logic [DATA_W-1:0] preload_q
);
    localparam int SIG_WORDS = SIG_BITS / DATA_W;
    localparam int SIG_AW    = $clog2(SIG_WORDS);

    op_e               op;
    logic              fire;
    logic              wipe_we, cfg_we, sig_we, pre_we;
    logic [ADDR_W-1:0] wipe_addr;
    logic              bank_we;
    logic [ADDR_W-1:0] bank_waddr;
    logic [DATA_W-1:0] bank_wdata;
    logic [DATA_W-1:0] cfg_rdata, sig_rdata;
    logic [SIG_AW-1:0] sig_idx;

    assign op      = op_e'(cmd_op);
    assign fire    = cmd_valid && cmd_ready;
    assign sig_idx = cmd_addr[SIG_AW-1:0];

    sec_ctrl_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_fire  (fire),
        .op        (op),
        .ready     (cmd_ready),
        .is_locked (locked),
        .wipe_we   (wipe_we),
        .wipe_addr (wipe_addr),
        .cfg_we    (cfg_we),
        .sig_we    (sig_we),
        .pre_we    (pre_we)
    );

    // the erase sweep owns the write port while it runs
    always_comb begin
        if (wipe_we) begin
            bank_we    = 1'b1;
            bank_waddr = wipe_addr;
            bank_wdata = '0;
        end else begin
            bank_we    = cfg_we;
            bank_waddr = cmd_addr;
            bank_wdata = cmd_wdata;
        end
    end

    sec_word_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bank_we),
        .waddr (bank_waddr),
        .wdata (bank_wdata),
        .raddr (cmd_addr),
        .rdata (cfg_rdata)
    );

    sec_word_bank #(.DATA_W(DATA_W), .ADDR_W(SIG_AW)) u_sig (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (sig_we),
        .waddr (sig_idx),
        .wdata (cmd_wdata),
        .raddr (sig_idx),
        .rdata (sig_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            preload_q <= '0;
        end else if (pre_we) begin
            preload_q <= cmd_wdata;
        end
    end

    // one-cycle response register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= fire;
            rsp_data  <= '0;
            rsp_err   <= 1'b0;
            if (fire) begin
                unique case (op)
                    OP_VERIFY: begin
                        if (locked) rsp_err <= 1'b1;
                        else        rsp_data <= cfg_rdata;
                    end
                    OP_PRELOAD: rsp_err <= locked;
                    OP_SIG_RD:  rsp_data <= sig_rdata;
                    OP_BAD:     rsp_err <= 1'b1;
                    OP_CFG_WR, OP_SIG_WR, OP_LOCK, OP_ERASE: ;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/sec_access_chk.sv
module sec_access_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [2:0]        cmd_op,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_data,
    input logic              rsp_err,
    input logic              locked,
    input logic [DATA_W-1:0] preload_q
);
    logic acc;
    assign acc = cmd_valid && cmd_ready;

    p_rsp_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid);

    p_no_spurious_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !rsp_valid);

    p_locked_verify_refused_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == 3'd1 && locked) |=> (rsp_err && rsp_data == '0));

    p_err_data_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_data == '0));

    p_locked_preload_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == 3'd2 && locked) |=> $stable(preload_q));

    p_erase_unlocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == 3'd6) |=> (!locked && !cmd_ready));

    p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !(acc && cmd_op == 3'd6)) |=> locked);

    p_lock_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == 3'd5) |=> locked);

endmodule

bind sec_access_ctrl sec_access_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_err   (rsp_err),
    .locked    (locked),
    .preload_q (preload_q)
);

// File: tb/sim_sec_access_ctrl.sv
`timescale 1ns/1ps
module sim_sec_access_ctrl;
    localparam int DW    = 8;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [2:0]    cmd_op = 3'd0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic          rsp_err;
    logic          locked;
    logic [DW-1:0] preload_q;

    always #4 clk = ~clk;

    sec_access_ctrl #(.DATA_W(DW), .ADDR_W(AW), .SIG_BITS(64)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
        .locked(locked), .preload_q(preload_q)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // behavioural reference state
    logic [DW-1:0] m_cfg [DEPTH];
    logic [DW-1:0] m_sig [8];
    bit            m_lock = 1'b0;
    logic [DW-1:0] m_pre = '0;
    int            busy = 0;
    bit            e_rv = 1'b0, e_re = 1'b0, e_ready = 1'b1;
    logic [DW-1:0] e_rd = '0;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input string tag, input bit v, input logic [2:0] op,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
        bit acc;
        @(negedge clk);
        chk(tag, "rsp_valid", 32'(rsp_valid), 32'(e_rv));
        chk(tag, "rsp_data",  32'(rsp_data),  32'(e_rd));
        chk(tag, "rsp_err",   32'(rsp_err),   32'(e_re));
        chk(tag, "cmd_ready", 32'(cmd_ready), 32'(e_ready));
        chk(tag, "locked",    32'(locked),    32'(m_lock));
        chk(tag, "preload_q", 32'(preload_q), 32'(m_pre));
        cmd_valid = v; cmd_op = op; cmd_addr = a; cmd_wdata = d;
        acc  = v && (busy == 0);
        e_rv = acc; e_rd = '0; e_re = 1'b0;
        if (busy > 0) begin
            busy--;
        end else if (acc) begin
            case (op)
                3'd0: m_cfg[a] = d;
                3'd1: if (m_lock) e_re = 1'b1; else e_rd = m_cfg[a];
                3'd2: if (m_lock) e_re = 1'b1; else m_pre = d;
                3'd3: e_rd = m_sig[a[2:0]];
                3'd4: m_sig[a[2:0]] = d;
                3'd5: m_lock = 1'b1;
                3'd6: begin
                    m_lock = 1'b0;
                    busy = DEPTH;
                    for (int i = 0; i < DEPTH; i++) m_cfg[i] = '0;
                end
                default: e_re = 1'b1;
            endcase
        end
        e_ready = (busy == 0);
    endtask

    task automatic idle(input string tag);
        step(tag, 1'b0, 3'd0, '0, '0);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) m_cfg[i] = '0;
        for (int i = 0; i < 8; i++) m_sig[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, including zeroed stores
        idle("R1");
        step("R1", 1'b1, 3'd1, 4'd9, '0);
        step("R1", 1'b1, 3'd3, 4'd5, '0);
        idle("R1");
        // R2: write and verify several patterns
        for (int i = 0; i < 6; i++) step("R2", 1'b1, 3'd0, AW'(i), DW'(8'h11 * (i + 1)));
        step("R2", 1'b1, 3'd0, 4'hF, 8'hC3);
        for (int i = 0; i < 6; i++) step("R2", 1'b1, 3'd1, AW'(i), '0);
        step("R2", 1'b1, 3'd1, 4'hF, '0);
        // R6: signature while unlocked
        for (int i = 0; i < 8; i++) step("R6", 1'b1, 3'd4, AW'(i), DW'(8'hA0 + i));
        for (int i = 0; i < 8; i++) step("R6", 1'b1, 3'd3, AW'(i + 8), '0);
        // R5: preload while unlocked
        step("R5", 1'b1, 3'd2, '0, 8'h5A);
        idle("R5");
        // R8: illegal opcode
        step("R8", 1'b1, 3'd7, 4'd2, 8'hFF);
        step("R8", 1'b1, 3'd1, 4'd2, '0);
        // R9: valid low between commands
        idle("R9");
        // R3: lock, then verify on the very next cycle
        step("R3", 1'b1, 3'd5, '0, '0);
        step("R3", 1'b1, 3'd1, 4'd1, '0);
        step("R4", 1'b1, 3'd1, 4'hF, '0);
        idle("R4");
        step("R5", 1'b1, 3'd2, '0, 8'h77);
        idle("R5");
        step("R6", 1'b1, 3'd4, 4'd3, 8'h3C);
        step("R6", 1'b1, 3'd3, 4'd3, '0);
        step("R6", 1'b1, 3'd3, 4'd7, '0);
        step("R10", 1'b1, 3'd0, 4'd4, 8'h99);
        step("R10", 1'b1, 3'd1, 4'd4, '0);
        step("R3", 1'b1, 3'd5, '0, '0);
        idle("R3");
        // R7: erase with a command held during the sweep (R9)
        step("R7", 1'b1, 3'd6, '0, '0);
        for (int i = 0; i < DEPTH + 1; i++) step("R9", 1'b1, 3'd2, '0, 8'hEE);
        idle("R7");
        for (int i = 0; i < DEPTH; i++) step("R7", 1'b1, 3'd1, AW'(i), '0);
        step("R6", 1'b1, 3'd3, 4'd0, '0);
        step("R5", 1'b1, 3'd2, '0, 8'h81);
        step("R7", 1'b1, 3'd0, 4'd2, 8'h42);
        step("R7", 1'b1, 3'd1, 4'd2, '0);
        idle("R9");
        idle("R9");
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule